// File: doc/BRIEF.md
# CAN Error Event Capture and Interrupt Unit

This block gathers error events reported by a CAN protocol engine and holds them in two byte-wide flag registers that software can read and acknowledge. One register records the class of the event (bus error, warning and passive limits, bus-off entry and recovery, receive overrun, overload frame, bus lock). The other records which kind of bus error was seen (stuff, form, ACK, CRC, both bit-error polarities, ACK delimiter). The protocol engine drives one single-cycle strobe per event kind. Software acknowledges a flag by writing 0 to its bit. Writing 1 to a bit leaves that flag as it is.

Each event-class flag has its own enable bit. A summary error flag in the interrupt status register is the registered OR of the enabled event-class flags. The interrupt pin is that summary flag gated by its own enable bit. The error-kind register has a display-mode bit. In accumulate mode it collects every error kind. In first-error mode it keeps only the first error seen until software clears it completely. The transmit and receive error counts, supplied by the engine, can be read back through the same register port.

The register port is a plain single-cycle write strobe with an address, and a combinational read selected by the same address. There is no data stream, so no valid/ready handshake is involved.

Top module: `can_err_unit`

## Requirements
- R1: After reset, every flag, enable, interrupt-enable and display-mode bit is 0, the summary flag is 0 and `err_irq_o` is low.
- R2: A strobe on `factor_evt_i[k]` sets bit k of the event-class register (address 0) at the next clock edge, and the bit stays set until software clears it. Bit order from 7 down to 0: bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error.
- R3: A write to address 0 clears exactly the flags whose written bit is 0 and leaves the flags whose written bit is 1 unchanged.
- R4: When an event strobe and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: The error-kind register (address 1) holds bits 6 down to 0: ACK delimiter error, bit error dominant, bit error recessive, CRC error, ACK error, form error, stuff error. With display-mode bit 7 at 1, every strobe on `code_evt_i` is ORed into the stored bits.
- R6: With display-mode bit 7 at 0, strobes are accepted only while bits 6..0 are all 0. Strobes that arrive together in one cycle while the register is empty are all stored. After that, any later strobe is ignored until software has cleared all of bits 6..0.
- R7: A write to address 1 clears the error-kind bits whose written bit is 0, keeps the ones whose written bit is 1, and loads bit 7 (display mode) from the written data.
- R8: The summary flag (bit 5 of the interrupt status register, address 4; other bits read 0) equals the OR of the event-class flags masked by the enable register (address 2), delayed by one cycle. A flag that is not enabled never asserts it. The summary flag deasserts in the cycle after the last enabled flag clears.
- R9: `err_irq_o` is high exactly when the summary flag is high and bit 5 of the interrupt-enable register (address 3) is 1.
- R10: Address 5 reads `tx_err_cnt_i` and address 6 reads `rx_err_cnt_i`. The enable registers read back what was written. Addresses 7 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| factor_evt_i | input | 8 | Event-class strobes from the protocol engine |
| code_evt_i | input | 7 | Error-kind strobes from the protocol engine |
| tx_err_cnt_i | input | 8 | Transmit error count from the protocol engine |
| rx_err_cnt_i | input | 8 | Receive error count from the protocol engine |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The assertions assume that event strobes are sampled only on the clock edge and that a register write lasts one cycle with a stable address. They also assume that the error counts are plain data with no protocol attached. Within those assumptions they check the set, hold and clear behaviour of the flags, the blocking rule of first-error mode, and the one-cycle relation between the masked flags and the summary flag. The bench changes every input on the falling edge and keeps each write and strobe to one cycle. It times same-cycle collisions of a strobe and a clear on purpose to cover the set-wins rule.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned CODE_W    = 7;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned SUM_BIT   = 5;
  localparam int unsigned MODE_BIT  = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_FACTOR = 3'd0,
    A_CODE   = 3'd1,
    A_FEN    = 3'd2,
    A_IEN    = 3'd3,
    A_ISTAT  = 3'd4,
    A_TXCNT  = 3'd5,
    A_RXCNT  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/cer_flag_bank.sv
module cer_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] q, keep_mask, set_mask;

  assign keep_mask = clr_we_i ? keep_i : {W{1'b1}};
  assign set_mask  = set_en_i ? set_i  : '0;

  // Set has priority over clear on a per-bit basis.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & keep_mask) | set_mask;
  end

  assign flags_o = q;

  p_set_sticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && !(set_en_i && set_i != '0)) |=> $stable(q));

  p_keep_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((($past(q) & $past(keep_i)) & ~q) == '0));

  p_rise_only_on_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q & ~$past(q) & ~($past(set_en_i) ? $past(set_i) : '0)) == '0));
endmodule

// File: rtl/cer_code_store.sv
module cer_code_store
  import can_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_evt_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  value_o
);
  logic              accum_q;
  logic              accept;
  logic [CODE_W-1:0] codes;

  // First-error mode admits new codes only into an empty store.
  assign accept = accum_q || (codes == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   accum_q <= 1'b0;
    else if (wr_i) accum_q <= wdata_i[MODE_BIT];
  end

  cer_flag_bank #(.W(CODE_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (accept),
    .set_i    (code_evt_i),
    .clr_we_i (wr_i),
    .keep_i   (wdata_i[CODE_W-1:0]),
    .flags_o  (codes)
  );

  assign value_o = {accum_q, codes};

  p_first_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accum_q && codes != '0 && !wr_i) |=> (codes == $past(codes)));

  p_accum_collects_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accum_q && !wr_i) |=> (codes == ($past(codes) | $past(code_evt_i))));

  p_mode_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (value_o[MODE_BIT] == $past(wdata_i[MODE_BIT])));
endmodule

// File: rtl/cer_irq_summary.sv
module cer_irq_summary
  import can_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] flags_i,
  input  logic [REG_W-1:0] enable_i,
  input  logic             irq_en_i,
  output logic             sum_o,
  output logic             irq_o
);
  logic sum_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sum_q <= 1'b0;
    else         sum_q <= |(flags_i & enable_i);
  end

  assign sum_o = sum_q;
  assign irq_o = sum_q & irq_en_i;

  p_sum_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sum_q == (($past(flags_i) & $past(enable_i)) != '0)));

  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & enable_i) == '0) |=> !sum_q);

  p_irq_needs_sum_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum_q && irq_en_i));
endmodule

// File: rtl/can_err_unit.sv
module can_err_unit
  import can_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [REG_W-1:0]  factor_evt_i,
  input  logic [CODE_W-1:0] code_evt_i,
  input  logic [REG_W-1:0]  tx_err_cnt_i,
  input  logic [REG_W-1:0]  rx_err_cnt_i,
  output logic              err_irq_o
);
  logic [REG_W-1:0] factor_q, code_val, fen_q, ien_q, istat;
  logic             sum;
  logic             wr_factor, wr_code, wr_fen, wr_ien;

  assign wr_factor = reg_wr_i && (reg_addr_i == A_FACTOR);
  assign wr_code   = reg_wr_i && (reg_addr_i == A_CODE);
  assign wr_fen    = reg_wr_i && (reg_addr_i == A_FEN);
  assign wr_ien    = reg_wr_i && (reg_addr_i == A_IEN);

  cer_flag_bank #(.W(REG_W)) u_factor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (1'b1),
    .set_i    (factor_evt_i),
    .clr_we_i (wr_factor),
    .keep_i   (reg_wdata_i),
    .flags_o  (factor_q)
  );

  cer_code_store u_code (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_evt_i (code_evt_i),
    .wr_i       (wr_code),
    .wdata_i    (reg_wdata_i),
    .value_o    (code_val)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fen_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_fen) fen_q <= reg_wdata_i;
      if (wr_ien) ien_q <= reg_wdata_i;
    end
  end

  cer_irq_summary u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (factor_q),
    .enable_i (fen_q),
    .irq_en_i (ien_q[SUM_BIT]),
    .sum_o    (sum),
    .irq_o    (err_irq_o)
  );

  always_comb begin
    istat          = '0;
    istat[SUM_BIT] = sum;
  end

  always_comb begin
    case (reg_addr_i)
      A_FACTOR: reg_rdata_o = factor_q;
      A_CODE:   reg_rdata_o = code_val;
      A_FEN:    reg_rdata_o = fen_q;
      A_IEN:    reg_rdata_o = ien_q;
      A_ISTAT:  reg_rdata_o = istat;
      A_TXCNT:  reg_rdata_o = tx_err_cnt_i;
      A_RXCNT:  reg_rdata_o = rx_err_cnt_i;
      default:  reg_rdata_o = '0;
    endcase
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (factor_q == '0 && code_val == '0 && !err_irq_o));

  p_cnt_view_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_TXCNT) |-> (reg_rdata_o == tx_err_cnt_i));
endmodule

// File: tb/test_can_err_unit.sv
module test_can_err_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] fevt = '0;
  logic [6:0] cevt = '0;
  logic [7:0] txc = 8'h00;
  logic [7:0] rxc = 8'h00;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  can_err_unit i_can_err_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .factor_evt_i(fevt),
    .code_evt_i(cevt), .tx_err_cnt_i(txc), .rx_err_cnt_i(rxc),
    .err_irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] f, input logic [6:0] c);
    @(negedge clk);
    fevt = f; cevt = c;
    @(negedge clk);
    fevt = '0; cevt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R1 reset", d, 8'h00);
    end
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_factor;
    logic [7:0] d;
    pulse(8'h81, '0);
    rd(3'd0, d); chk("R2 set bus lock+bus error", d, 8'h81);
    pulse(8'h10, '0);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R2 held", d, 8'h91);
    wr_reg(3'd0, 8'hFE);
    rd(3'd0, d); chk("R3 clear bit0 only", d, 8'h90);
    wr_reg(3'd0, 8'hFF);
    rd(3'd0, d); chk("R3 ones keep", d, 8'h90);
    wr_reg(3'd0, 8'h00);
    rd(3'd0, d); chk("R3 clear all", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    pulse(8'h11, '0);
    @(negedge clk);
    wr = 1'b1; addr = 3'd0; wdata = 8'h00; fevt = 8'h01;
    @(negedge clk);
    wr = 1'b0; fevt = '0;
    rd(3'd0, d); chk("R4 set wins over clear", d, 8'h01);
    wr_reg(3'd0, 8'h00);
  endtask

  task automatic t_accum;
    logic [7:0] d;
    wr_reg(3'd1, 8'h80);
    pulse('0, 7'h20);
    pulse('0, 7'h04);
    rd(3'd1, d); chk("R5 accumulate", d, 8'hA4);
    wr_reg(3'd1, 8'hFB);
    rd(3'd1, d); chk("R7 clear bit2 keep mode", d, 8'hA0);
  endtask

  task automatic t_first;
    logic [7:0] d;
    wr_reg(3'd1, 8'h00);
    rd(3'd1, d); chk("R7 clear and mode 0", d, 8'h00);
    pulse('0, 7'h08);
    rd(3'd1, d); chk("R6 first code kept", d, 8'h08);
    pulse('0, 7'h01);
    rd(3'd1, d); chk("R6 later code ignored", d, 8'h08);
    wr_reg(3'd1, 8'h00);
    pulse('0, 7'h03);
    rd(3'd1, d); chk("R6 simultaneous codes on empty", d, 8'h03);
    wr_reg(3'd1, 8'h01);
    pulse('0, 7'h40);
    rd(3'd1, d); chk("R6 blocked until fully empty", d, 8'h01);
    wr_reg(3'd1, 8'h00);
  endtask

  task automatic t_summary;
    logic [7:0] d;
    wr_reg(3'd2, 8'h04);
    rd(3'd2, d); chk("R10 enable readback", d, 8'h04);
    pulse(8'h02, '0);
    @(negedge clk);
    rd(3'd4, d); chk("R8 masked flag quiet", d, 8'h00);
    pulse(8'h04, '0);
    rd(3'd4, d); chk("R8 not yet (one cycle delay)", d, 8'h00);
    @(negedge clk);
    rd(3'd4, d); chk("R8 summary set", d, 8'h20);
    chk("R9 irq gated off", {7'd0, irq}, 8'h00);
    wr_reg(3'd3, 8'h20);
    chk("R9 irq on", {7'd0, irq}, 8'h01);
    wr_reg(3'd0, 8'hFB);
    rd(3'd4, d); chk("R8 still set right after clear", d, 8'h20);
    @(negedge clk);
    rd(3'd4, d); chk("R8 deasserts next cycle", d, 8'h00);
    chk("R9 irq off", {7'd0, irq}, 8'h00);
    wr_reg(3'd0, 8'h00);
  endtask

  task automatic t_counts;
    logic [7:0] d;
    txc = 8'h5A; rxc = 8'hC3;
    @(negedge clk);
    rd(3'd5, d); chk("R10 tx count", d, 8'h5A);
    rd(3'd6, d); chk("R10 rx count", d, 8'hC3);
    rd(3'd7, d); chk("R10 unused addr", d, 8'h00);
    rd(3'd3, d); chk("R10 irq enable readback", d, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_factor;
    t_collide;
    t_accum;
    t_first;
    t_summary;
    t_counts;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule